// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block holds the per-frame transmit results that a host driver collects after frames leave the wire. Each time the transmit engine finishes a frame it strobes a result byte into the block. The block keeps these results in arrival order. The oldest result is presented on an 8-bit read port, and any host write strobe on that port discards that result so the next one comes up.

The queue has a fixed capacity set by a parameter. A result that arrives while every slot is occupied is not stored. Instead, the block marks the loss in the entry currently on top, so the host learns that at least one result went missing.

Two signals go to the transmit control logic:
- A one-cycle event pulse whenever a result asks for an interrupt or reports an error.
- A level that holds the transmitter stopped after a jabber or underrun result. This level stays up until the control logic issues a transmit reset strobe. That strobe also empties the queue.

Top module: `txc_status_stack`

## Requirements
- R1: After a synchronous active-low reset, `host_rd_data` is 0x00 and `txc_event` and `tx_halt` are low.
- R2: While the queue is empty, `host_rd_data` reads 0x00, so bit 7 (done) is clear. A host write strobe on an empty queue changes nothing.
- R3: An accepted result appears on `host_rd_data` as follows: bit 7 forced to 1, bits 6..3 copied from the pushed byte, and bits 2..0 cleared. Bit 6 is the interrupt request, bit 5 jabber, bit 4 underrun and bit 3 maximum collisions. A result pushed into an empty queue is visible in the cycle after its clock edge.
- R4: Results are reported oldest first. Each host write strobe removes exactly one entry, and the next-oldest entry shows from the following cycle.
- R5: The queue holds `DEPTH` entries (default 4). A push while full, without a pop in the same cycle, is dropped. It sets bit 2 (results lost) of the entry then on top, and that bit stays set until the entry is popped.
- R6: A push and a pop in the same cycle on a full queue both take effect, and no loss is recorded.
- R7: `txc_event` pulses high for exactly one cycle, in the cycle after a push whose bit 6, 5, 4 or 3 is set. This happens even when the push is dropped. A push with none of these bits set raises no pulse.
- R8: `tx_halt` rises in the cycle after a push with bit 5 or bit 4 set. It stays high, whatever else is pushed or popped, until a transmit reset strobe.
- R9: A `tx_reset` strobe empties the queue and clears `tx_halt`. A push or pop in the same cycle is ignored: nothing is stored and no event or halt results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_vld | input | 1 | Transmit engine offers a result this cycle |
| push_byte | input | 8 | Result byte from the transmit engine |
| host_wr | input | 1 | Host write strobe on the status port; pops the top entry |
| tx_reset | input | 1 | Transmit reset strobe from the control logic |
| host_rd_data | output | 8 | Top entry, or 0x00 when empty |
| txc_event | output | 1 | One-cycle pulse for an interrupt-worthy result |
| tx_halt | output | 1 | Transmitter must stay stopped until reset |

## Verification
A bad read or write pointer shows on `host_rd_data` in the very next cycle: a stale or reordered byte, or a done bit on an empty queue. A count that drifts by one shows up later. It appears only at the capacity edge, as a lost result that should have been stored, or a stored one that should have been flagged. For that reason the stimulus repeatedly drives the queue to full and past it. A halt latch that clears itself, or an event pulse that stretches, differs from the model one cycle after the push that caused it.

// File: rtl/txc_pkg.sv
// Package: bit positions of the transmit completion result byte.
// Assumes an 8-bit result byte; bits 1..0 carry no meaning and read as 0.
package txc_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned B_DONE   = 7;
    localparam int unsigned B_IRQ    = 6;
    localparam int unsigned B_JABBER = 5;
    localparam int unsigned B_UNDER  = 4;
    localparam int unsigned B_MAXCOL = 3;
    localparam int unsigned B_LOST   = 2;

    typedef logic [BYTE_W-1:0] txc_byte_t;
endpackage

// File: rtl/txc_push_fmt.sv
// Module: txc_push_fmt
// Purely combinational. Turns a raw result byte from the transmit engine
// into the stored form and classifies it.
// Assumes the block, not the transmit engine, owns the done and lost bits.
module txc_push_fmt
    import txc_pkg::*;
(
    input  txc_byte_t raw_byte,
    output txc_byte_t entry_byte,
    output logic      wants_event,
    output logic      needs_reset
);
    // Build the stored entry: done forced, reason bits kept, low bits cleared
    always_comb begin
        entry_byte         = '0;
        entry_byte[B_DONE] = 1'b1;
        entry_byte[B_IRQ]    = raw_byte[B_IRQ];
        entry_byte[B_JABBER] = raw_byte[B_JABBER];
        entry_byte[B_UNDER]  = raw_byte[B_UNDER];
        entry_byte[B_MAXCOL] = raw_byte[B_MAXCOL];
    end

    // Classify: interrupt request or any error, and the fatal error subset
    always_comb begin
        wants_event = raw_byte[B_IRQ] | raw_byte[B_JABBER]
                    | raw_byte[B_UNDER] | raw_byte[B_MAXCOL];
        needs_reset = raw_byte[B_JABBER] | raw_byte[B_UNDER];
    end
endmodule

// File: rtl/txc_store.sv
// Module: txc_store
// Circular buffer of DEPTH result bytes, oldest presented on top_byte.
// A push while full (and no pop) marks the lost bit in the top entry.
// Assumes flush has priority over push and pop; DEPTH >= 1.
module txc_store
    import txc_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  txc_byte_t push_entry,
    input  logic      pop,
    input  logic      flush,
    output txc_byte_t top_byte
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    txc_byte_t       slots [DEPTH];
    logic [PW-1:0]   rd_ptr;
    logic [PW-1:0]   wr_ptr;
    logic [CW-1:0]   count;
    logic            is_empty;
    logic            is_full;
    logic            do_pop;
    logic            do_push;
    logic            do_mark;

    // Decode occupancy and decide which operations take effect this cycle
    always_comb begin
        is_empty = (count == '0);
        is_full  = (count == FULL_CNT);
        do_pop   = !flush && pop && !is_empty;
        do_push  = !flush && push && (!is_full || do_pop);
        do_mark  = !flush && push && is_full && !do_pop;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (do_push)
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Slot contents: store accepted entries, mark loss on the top slot
    always_ff @(posedge clk) begin
        if (do_push)
            slots[wr_ptr] <= push_entry;
        else if (do_mark)
            slots[rd_ptr][B_LOST] <= 1'b1;
    end

    // Present the oldest entry, or zero when nothing is held
    always_comb begin
        top_byte = is_empty ? '0 : slots[rd_ptr];
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (top_byte == '0)); // R9
    AST_LOSS_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop && !flush) |=> top_byte[B_LOST]); // R5
    AST_TOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_empty |-> top_byte[B_DONE]); // R3
endmodule

// File: rtl/txc_ctrl_flags.sv
// Module: txc_ctrl_flags
// Registers the event pulse and the sticky halt level for the
// transmit control logic. Assumes flush outranks a same-cycle push.
module txc_ctrl_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic wants_event,
    input  logic needs_reset,
    input  logic flush,
    output logic event_pulse,
    output logic halt
);
    // One-cycle event for every interrupt-worthy push
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            event_pulse <= 1'b0;
        else
            event_pulse <= push && wants_event;
    end

    // Sticky halt until the transmit reset strobe
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            halt <= 1'b0;
        else if (push && needs_reset)
            halt <= 1'b1;
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !flush) |=> halt); // R8
    AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> $past(push)); // R7
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!event_pulse && !halt)); // R9
endmodule

// File: rtl/txc_status_stack.sv
// Module: txc_status_stack (top)
// Queue of transmit completion results read and popped by the host
// through one 8-bit port, with event and halt outputs to the control logic.
// Assumes host_wr is a single-cycle strobe per host write.
module txc_status_stack
    import txc_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_vld,
    input  logic [7:0] push_byte,
    input  logic       host_wr,
    input  logic       tx_reset,
    output logic [7:0] host_rd_data,
    output logic       txc_event,
    output logic       tx_halt
);
    txc_byte_t entry_byte;
    txc_byte_t top_byte;
    logic      wants_event;
    logic      needs_reset;

    txc_push_fmt u_fmt (
        .raw_byte    (push_byte),
        .entry_byte  (entry_byte),
        .wants_event (wants_event),
        .needs_reset (needs_reset)
    );

    txc_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_vld),
        .push_entry (entry_byte),
        .pop        (host_wr),
        .flush      (tx_reset),
        .top_byte   (top_byte)
    );

    txc_ctrl_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push_vld),
        .wants_event (wants_event),
        .needs_reset (needs_reset),
        .flush       (tx_reset),
        .event_pulse (txc_event),
        .halt        (tx_halt)
    );

    // Drive the host read port from the top of the queue
    always_comb begin
        host_rd_data = top_byte;
    end

    AST_EMPTY_POP_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !push_vld && !tx_reset && host_rd_data == 8'h00)
        |=> (host_rd_data == 8'h00)); // R2
endmodule

// File: tb/txc_status_stack_tb_top.sv
module txc_status_stack_tb_top;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_vld = 1'b0;
    logic [7:0] push_byte = 8'h00;
    logic       host_wr = 1'b0;
    logic       tx_reset = 1'b0;
    logic [7:0] host_rd_data;
    logic       txc_event;
    logic       tx_halt;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    logic [7:0] mq[$];
    logic       m_ev = 1'b0;
    logic       m_halt = 1'b0;

    always #4 clk = ~clk;

    txc_status_stack #(.DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_vld     (push_vld),
        .push_byte    (push_byte),
        .host_wr      (host_wr),
        .tx_reset     (tx_reset),
        .host_rd_data (host_rd_data),
        .txc_event    (txc_event),
        .tx_halt      (tx_halt)
    );

    // Behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n || tx_reset) begin
            mq.delete();
            m_ev = 1'b0;
            m_halt = 1'b0;
        end else begin
            m_ev = push_vld && (push_byte[6] || push_byte[5] || push_byte[4] || push_byte[3]);
            if (push_vld && (push_byte[5] || push_byte[4])) m_halt = 1'b1;
            if (host_wr && mq.size() > 0) void'(mq.pop_front());
            if (push_vld) begin
                if (mq.size() < DEPTH) mq.push_back({1'b1, push_byte[6:3], 3'b000});
                else mq[0][2] = 1'b1;
            end
        end
        cycles++;
    end

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %02h expected %02h at cycle %0d",
                     cur_tag, what, act, exp, cycles);
        end
    endtask

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("rd_data", host_rd_data, (mq.size() > 0) ? mq[0] : 8'h00);
            check("event", {7'd0, txc_event}, {7'd0, m_ev});
            check("halt", {7'd0, tx_halt}, {7'd0, m_halt});
        end
    end

    task automatic cyc(input logic p, input logic [7:0] b, input logic w, input logic r);
        @(negedge clk);
        push_vld = p;
        push_byte = b;
        host_wr = w;
        tx_reset = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(8 * 100000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        cur_tag = "R1";
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        cur_tag = "R2";  // pop on empty queue
        cyc(1'b0, 8'hFF, 1'b1, 1'b0);
        idle(2);

        cur_tag = "R3";  // formatting of stored entries, no event for plain result
        cyc(1'b1, 8'h07, 1'b0, 1'b0);
        idle(1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        cyc(1'b1, 8'hC8, 1'b0, 1'b0);
        idle(1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        idle(1);

        cur_tag = "R4";  // ordering and single pops
        cyc(1'b1, 8'h80, 1'b0, 1'b0);
        cyc(1'b1, 8'h40, 1'b0, 1'b0);
        cyc(1'b1, 8'h08, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0);
        idle(1);

        cur_tag = "R5";  // fill, overflow twice, drain
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 8'h80, 1'b0, 1'b0);
        cyc(1'b1, 8'h40, 1'b0, 1'b0);
        cyc(1'b1, 8'h08, 1'b0, 1'b0);
        idle(2);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        cur_tag = "R6";  // refill to full, then push with pop
        cyc(1'b1, 8'h48, 1'b0, 1'b0);
        cyc(1'b1, 8'h40, 1'b1, 1'b0);
        cyc(1'b1, 8'h88, 1'b1, 1'b0);
        idle(1);
        for (int i = 0; i < DEPTH + 1; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0);

        cur_tag = "R7";  // back-to-back events and quiet pushes
        cyc(1'b1, 8'h40, 1'b0, 1'b0);
        cyc(1'b1, 8'h40, 1'b0, 1'b0);
        cyc(1'b1, 8'h80, 1'b0, 1'b0);
        cyc(1'b1, 8'h08, 1'b0, 1'b0);
        cyc(1'b1, 8'h47, 1'b0, 1'b0);
        idle(2);

        cur_tag = "R8";  // jabber then unrelated traffic
        cyc(1'b1, 8'h20, 1'b0, 1'b1);
        cyc(1'b1, 8'h20, 1'b0, 1'b0);
        cyc(1'b1, 8'h80, 1'b1, 1'b0);
        idle(3);
        cur_tag = "R9";
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        idle(2);
        cur_tag = "R8";  // underrun path
        cyc(1'b1, 8'h10, 1'b0, 1'b0);
        idle(2);

        cur_tag = "R9";  // reset with same-cycle push and pop
        cyc(1'b1, 8'h30, 1'b1, 1'b1);
        idle(2);

        cur_tag = "R4";  // mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            cyc(rv[0] | rv[1], rv[15:8], rv[2] & rv[3], (rv[7:4] == 4'hF) && rv[16]);
        end
        idle(2);

        cur_tag = "R1";  // reset mid-run
        for (int i = 0; i < 3; i++) cyc(1'b1, 8'h30, 1'b0, 1'b0);
        @(negedge clk) begin
            rst_n = 1'b0;
            push_vld = 1'b0;
        end
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        finish_run();
    end
endmodule